// File: doc/BRIEF.md
# Exact Fixed-Window Floating-Point Accumulator

This block sums a stream of IEEE-754 binary32 values without rounding along the way. Each input is shifted into a wide two's-complement register. The bit weights of that register run from `LSB_W` up to `MSB_W`, plus one sign bit. Every enabled cycle takes one input.

A start strobe that comes with an input opens a new data set. That input replaces the running sum instead of being added to it. Sets may be of any length, and a new one may begin on any cycle.

The running sum goes back out as a binary32 value. The output conversion normalises the sum and truncates toward zero. Three sticky flags travel with the result and cover the current set:
- input too large (or infinity/NaN);
- input too small for the window;
- accumulator overflow.

Top module: `wide_fp_accum`

## Requirements
- R1: Each input with exponent field e (1..254) and unbiased exponent E = e-127 adds, to an exact internal sum, its magnitude {1,frac}·2^(E-23) truncated toward zero to a multiple of 2^LSB_W, with the sign bit 31 applied afterwards.
- R2: An input presented with `start` high replaces the internal sum, and its flags replace the sticky flags. `acc_ovf` is cleared by that input.
- R3: The result and the flags for an input appear on the outputs after the third enabled rising edge. The first of these edges is the one that samples the input.
- R4: `x_hi` is raised by an input with exponent field 255, or with E > IN_MSB_MAX. It stays high until the next `start`, and such an input adds nothing to the sum.
- R5: `x_lo` is raised by an input with exponent field 1..254 and E < LSB_W. It stays high until the next `start`, and the result still equals the sum of R1.
- R6: `acc_ovf` is raised when the sum leaves the signed range of MSB_W-LSB_W+2 bits, in units of 2^LSB_W. It stays high until the next `start`.
- R7: An input with exponent field 0 (zero or subnormal) adds nothing and raises no flag. A zero sum is output as 32'h00000000.
- R8: A nonzero sum is output as sign, biased exponent (position of its leading one plus LSB_W plus 127) and the next 23 bits, truncated toward zero.
- R9: While `en` is low, inputs and `start` are ignored and all outputs hold their values.
- R10: A synchronous active-low `rst_n` clears the sum, the flags and `r_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Pipeline advance enable |
| x_in | input | 32 | binary32 input value |
| start | input | 1 | First element of a new data set |
| r_out | output | 32 | Running sum as binary32 |
| x_hi | output | 1 | Sticky input-above-window flag |
| x_lo | output | 1 | Sticky input-below-window flag |
| acc_ovf | output | 1 | Sticky accumulator overflow flag |

## Verification
The embedded properties assume that `x_in`, `start` and `en` carry known values on every enabled edge after reset. They also assume that `start` marks a real first element and is high for a single enabled cycle. The stimulus drives only defined values, raising `start` once per set and dropping it on the next drive. Random sets keep exponents at or below 12 so that no random set can overflow the window. Overflow, infinity, out-of-range inputs and disabled cycles carrying junk start strobes are placed deliberately in directed sets.

// File: rtl/wfa_pkg.sv
// Shared binary32 field constants for the fixed-window accumulator.
// Assumes IEEE-754 single precision layout: sign[31], exponent[30:23], fraction[22:0].
package wfa_pkg;
    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_BIAS   = 127;
    localparam int FP_SIG_W  = FP_FRAC_W + 1;
    localparam logic [FP_EXP_W-1:0] FP_EXP_MAX = '1;
endpackage

// File: rtl/wfa_align.sv
// Stage 1: decodes a binary32 input, classifies its range against the window
// and shifts it into a W-bit two's-complement value in units of 2^LSB_W.
// Assumes IN_MSB_MAX < MSB_W so an in-range input always fits the window.
module wfa_align
    import wfa_pkg::*;
#(
    parameter int LSB_W      = -30,
    parameter int IN_MSB_MAX = 16,
    parameter int W          = 52
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [31:0]         x_in,
    input  logic                start_in,
    output logic [W-1:0]        val_q,
    output logic                start_q,
    output logic                hi_q,
    output logic                lo_q
);
    localparam int WIDE_W = W + FP_SIG_W;

    logic [FP_EXP_W-1:0]  exp_f;
    logic                 is_zero;
    logic                 is_hi;
    logic                 is_lo;
    int                   e_unb;
    int                   sh;
    logic [WIDE_W-1:0]    wide;
    logic [W-1:0]         mag;
    logic [W-1:0]         sval;

    // Classify the input and shift its significand to the window weight.
    always_comb begin
        exp_f   = x_in[30:23];
        e_unb   = int'(exp_f) - FP_BIAS;
        is_zero = (exp_f == '0);
        is_hi   = (exp_f == FP_EXP_MAX) || (!is_zero && (e_unb > IN_MSB_MAX));
        is_lo   = !is_zero && !is_hi && (e_unb < LSB_W);
        sh      = e_unb + 1 - LSB_W;
        wide    = '0;
        if (!is_zero && !is_hi && (sh >= 0))
            wide = {{W{1'b0}}, 1'b1, x_in[FP_FRAC_W-1:0]} << sh;
        mag  = wide[WIDE_W-1:FP_SIG_W];
        sval = x_in[31] ? (~mag + 1'b1) : mag;
    end

    // Register the aligned value with its strobe and range flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= '0;
            start_q <= 1'b0;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
        end else if (en) begin
            val_q   <= sval;
            start_q <= start_in;
            hi_q    <= is_hi;
            lo_q    <= is_lo;
        end
    end

    AST_ZERO_IN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (x_in[30:23] == '0)) |=> ((val_q == '0) && !hi_q && !lo_q)); // R7
    AST_SPECIAL_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (x_in[30:23] == FP_EXP_MAX)) |=> (hi_q && (val_q == '0))); // R4
endmodule

// File: rtl/wfa_sum.sv
// Stage 2: exact two's-complement accumulator with sticky per-set flags.
// Assumes the aligned input fits W bits; overflow wraps and is flagged.
module wfa_sum #(
    parameter int W = 52
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  add_in,
    input  logic          start_in,
    input  logic          hi_in,
    input  logic          lo_in,
    output logic [W-1:0]  acc_q,
    output logic          hi_q,
    output logic          lo_q,
    output logic          ovf_q
);
    logic [W:0] ext;
    logic       add_ovf;

    // Sign-extended sum and signed overflow detection.
    always_comb begin
        ext     = {add_in[W-1], add_in} + {acc_q[W-1], acc_q};
        add_ovf = ext[W] ^ ext[W-1];
    end

    // Load on a new set, otherwise add and accumulate sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else if (en) begin
            if (start_in) begin
                acc_q <= add_in;
                hi_q  <= hi_in;
                lo_q  <= lo_in;
                ovf_q <= 1'b0;
            end else begin
                acc_q <= ext[W-1:0];
                hi_q  <= hi_q | hi_in;
                lo_q  <= lo_q | lo_in;
                ovf_q <= ovf_q | add_ovf;
            end
        end
    end

    AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_in && hi_q) |=> hi_q); // R4
    AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_in && lo_q) |=> lo_q); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start_in && ovf_q) |=> ovf_q); // R6
    AST_START_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start_in) |=> !ovf_q); // R2
    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc_q) && $stable(hi_q) && $stable(lo_q) && $stable(ovf_q))); // R9
endmodule

// File: rtl/wfa_pack.sv
// Stage 3: converts the W-bit accumulator back to binary32 by leading-zero
// count and truncation toward zero; registers result and flags together.
// Assumes W >= 24 and that the biased exponent range stays inside 1..254.
module wfa_pack
    import wfa_pkg::*;
#(
    parameter int W     = 52,
    parameter int LSB_W = -30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  acc_in,
    input  logic          hi_in,
    input  logic          lo_in,
    input  logic          ovf_in,
    output logic [31:0]   r_q,
    output logic          hi_q,
    output logic          lo_q,
    output logic          ovf_q
);
    logic [W-1:0]          mag;
    logic [W-1:0]          norm;
    int                    lz;
    logic [FP_EXP_W-1:0]   bexp;
    logic [31:0]           packed_r;

    // Magnitude, leading-zero count, normalisation and field packing.
    always_comb begin
        mag = acc_in[W-1] ? (~acc_in + 1'b1) : acc_in;
        lz  = W;
        for (int i = 0; i < W; i++)
            if (mag[i]) lz = W - 1 - i;
        norm     = mag << lz;
        bexp     = FP_EXP_W'(W - 1 - lz + LSB_W + FP_BIAS);
        packed_r = (mag == '0) ? 32'h0
                 : {acc_in[W-1], bexp, norm[W-2 -: FP_FRAC_W]};
    end

    // Output register for the result and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '0;
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else if (en) begin
            r_q   <= packed_r;
            hi_q  <= hi_in;
            lo_q  <= lo_in;
            ovf_q <= ovf_in;
        end
    end

    AST_ZERO_SUM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (acc_in == '0)) |=> (r_q == 32'h0)); // R7
    AST_NONZERO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (acc_in != '0)) |=> ((r_q[30:23] != '0) && (r_q[30:23] != FP_EXP_MAX))); // R8
    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (acc_in != '0)) |=> (r_q[31] == $past(acc_in[W-1]))); // R8
endmodule

// File: rtl/wide_fp_accum.sv
// Top: three-stage exact binary32 accumulator over a fixed-point window
// spanning weights LSB_W..MSB_W plus sign. Latency is three enabled edges.
// Assumes IN_MSB_MAX < MSB_W, LSB_W + 127 >= 1 and MSB_W + 128 <= 254.
module wide_fp_accum #(
    parameter int LSB_W      = -30,
    parameter int MSB_W      = 20,
    parameter int IN_MSB_MAX = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [31:0] x_in,
    input  logic        start,
    output logic [31:0] r_out,
    output logic        x_hi,
    output logic        x_lo,
    output logic        acc_ovf
);
    localparam int W = MSB_W - LSB_W + 2;

    logic [W-1:0] al_val;
    logic         al_start;
    logic         al_hi;
    logic         al_lo;
    logic [W-1:0] sm_acc;
    logic         sm_hi;
    logic         sm_lo;
    logic         sm_ovf;

    wfa_align #(.LSB_W(LSB_W), .IN_MSB_MAX(IN_MSB_MAX), .W(W)) u_align (
        .clk(clk), .rst_n(rst_n), .en(en), .x_in(x_in), .start_in(start),
        .val_q(al_val), .start_q(al_start), .hi_q(al_hi), .lo_q(al_lo)
    );

    wfa_sum #(.W(W)) u_sum (
        .clk(clk), .rst_n(rst_n), .en(en), .add_in(al_val), .start_in(al_start),
        .hi_in(al_hi), .lo_in(al_lo),
        .acc_q(sm_acc), .hi_q(sm_hi), .lo_q(sm_lo), .ovf_q(sm_ovf)
    );

    wfa_pack #(.W(W), .LSB_W(LSB_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .en(en), .acc_in(sm_acc),
        .hi_in(sm_hi), .lo_in(sm_lo), .ovf_in(sm_ovf),
        .r_q(r_out), .hi_q(x_hi), .lo_q(x_lo), .ovf_q(acc_ovf)
    );

    AST_OUT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(r_out) && $stable(x_hi) && $stable(x_lo) && $stable(acc_ovf))); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ((r_out == 32'h0) && !x_hi && !x_lo && !acc_ovf)); // R10
endmodule

// File: tb/sim_wide_fp_accum.sv
module sim_wide_fp_accum;
    localparam int LSB_W      = -30;
    localparam int MSB_W      = 20;
    localparam int IN_MSB_MAX = 16;
    localparam int W          = MSB_W - LSB_W + 2;
    localparam longint S_MAX  = (longint'(1) <<< (W - 1)) - 1;
    localparam longint S_MIN  = -(longint'(1) <<< (W - 1));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] x_in = '0;
    logic        start = 1'b0;
    logic [31:0] r_out;
    logic        x_hi, x_lo, acc_ovf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    longint m_sum = 0;
    bit m_hi = 0, m_lo = 0, m_ovf = 0;
    bit drv_en = 0;
    logic [31:0] s_r [3];
    bit s_hi [3], s_lo [3], s_ovf [3], s_rchk [3];
    logic [31:0] p_r = '0;
    bit p_hi = 0, p_lo = 0, p_ovf = 0, p_rchk = 1;

    wide_fp_accum #(.LSB_W(LSB_W), .MSB_W(MSB_W), .IN_MSB_MAX(IN_MSB_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .x_in(x_in), .start(start),
        .r_out(r_out), .x_hi(x_hi), .x_lo(x_lo), .acc_ovf(acc_ovf)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic bit hi_m(input logic [31:0] v);
        int e = int'(v[30:23]) - 127;
        return (v[30:23] == 8'hFF) || (v[30:23] != 0 && e > IN_MSB_MAX);
    endfunction

    function automatic bit lo_m(input logic [31:0] v);
        int e = int'(v[30:23]) - 127;
        return (v[30:23] != 0) && !hi_m(v) && (e < LSB_W);
    endfunction

    function automatic longint val_m(input logic [31:0] v);
        longint mag;
        int sh;
        if (v[30:23] == 0 || hi_m(v)) return 0;
        sh  = int'(v[30:23]) - 127 - 23 - LSB_W;
        mag = longint'({1'b1, v[22:0]});
        if (sh >= 0) mag = mag <<< sh;
        else if (-sh >= 24) mag = 0;
        else mag = mag >>> (-sh);
        return v[31] ? -mag : mag;
    endfunction

    function automatic logic [31:0] to_f(input longint s);
        logic [63:0] mu;
        logic [63:0] sig;
        int p;
        if (s == 0) return 32'h0;
        mu = (s < 0) ? 64'(-s) : 64'(s);
        p = 63;
        while (!mu[p]) p--;
        sig = (p >= 23) ? (mu >> (p - 23)) : (mu << (23 - p));
        return {s < 0, 8'(p + LSB_W + 127), sig[22:0]};
    endfunction

    function automatic logic [31:0] rnd_x();
        int k = $urandom_range(0, 99);
        logic [31:0] f = $urandom;
        int e;
        if (k < 6)       return {f[31], 8'h00, f[22:0] & {23{k[0]}}};
        else if (k < 9)  e = (k == 8) ? 128 : $urandom_range(IN_MSB_MAX + 1, IN_MSB_MAX + 10);
        else if (k < 16) e = $urandom_range(LSB_W - 12, LSB_W - 1);
        else             e = $urandom_range(LSB_W - 20, 12);
        return {f[31], 8'(e + 127), f[22:0]};
    endfunction

    // One cycle: advance the expected pipeline, check outputs, drive inputs.
    task automatic step(input logic [31:0] v, input bit st, input bit e);
        @(negedge clk);
        if (drv_en) begin
            for (int i = 2; i > 0; i--) begin
                s_r[i] = s_r[i-1]; s_hi[i] = s_hi[i-1]; s_lo[i] = s_lo[i-1];
                s_ovf[i] = s_ovf[i-1]; s_rchk[i] = s_rchk[i-1];
            end
            s_r[0] = p_r; s_hi[0] = p_hi; s_lo[0] = p_lo; s_ovf[0] = p_ovf; s_rchk[0] = p_rchk;
        end
        if (s_rchk[2])
            chk(r_out === s_r[2], drv_en ? "R1 result" : "R9 result held", r_out, s_r[2]);
        chk(x_hi === s_hi[2], "R4 x_hi", 32'(x_hi), 32'(s_hi[2]));
        chk(x_lo === s_lo[2], "R5 x_lo", 32'(x_lo), 32'(s_lo[2]));
        chk(acc_ovf === s_ovf[2], "R6 acc_ovf", 32'(acc_ovf), 32'(s_ovf[2]));
        if (e) begin
            if (st) begin
                m_sum = val_m(v); m_hi = hi_m(v); m_lo = lo_m(v); m_ovf = 0;
            end else begin
                m_sum += val_m(v); m_hi |= hi_m(v); m_lo |= lo_m(v);
            end
            if (m_sum > S_MAX || m_sum < S_MIN) m_ovf = 1;
            p_r = to_f(m_sum); p_hi = m_hi; p_lo = m_lo; p_ovf = m_ovf;
            p_rchk = !m_hi && !m_ovf;
        end
        x_in = v; start = st; en = e; drv_en = e;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(32'h0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 3; i++) begin
            s_r[i] = '0; s_hi[i] = 0; s_lo[i] = 0; s_ovf[i] = 0; s_rchk[i] = 1;
        end
        en = 1'b1;
        x_in = 32'h3F800000;
        repeat (3) @(posedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(r_out === 32'h0 && !x_hi && !x_lo && !acc_ovf, "R10 reset state", r_out, 32'h0);
        rst_n = 1'b1;

        // R3: latency of three enabled edges
        step(32'h3F800000, 1'b1, 1'b1);
        step(32'h0, 1'b0, 1'b1);
        step(32'h0, 1'b0, 1'b1);
        chk(r_out === 32'h0, "R3 not yet visible", r_out, 32'h0);
        step(32'h0, 1'b0, 1'b1);
        chk(r_out === 32'h3F800000, "R3 visible after third edge", r_out, 32'h3F800000);

        // R2: start replaces the sum
        step(32'h40A00000, 1'b1, 1'b1);
        step(32'h40000000, 1'b1, 1'b1);
        flush();
        chk(r_out === 32'h40000000, "R2 start replaces sum", r_out, 32'h40000000);

        // R7: cancellation and subnormal input give exact zero
        step(32'h3F800000, 1'b1, 1'b1);
        step(32'hBF800000, 1'b0, 1'b1);
        step(32'h00012345, 1'b0, 1'b1);
        flush();
        chk(r_out === 32'h0 && !x_lo && !x_hi, "R7 zero sum", r_out, 32'h0);

        // R8: truncation toward zero for both signs
        step(32'h3F800000, 1'b1, 1'b1);
        step(32'h30800000, 1'b0, 1'b1);
        flush();
        chk(r_out === 32'h3F800000, "R8 truncate positive", r_out, 32'h3F800000);
        step(32'hBF800000, 1'b1, 1'b1);
        step(32'hB0800000, 1'b0, 1'b1);
        flush();
        chk(r_out === 32'hBF800000, "R8 truncate negative", r_out, 32'hBF800000);

        // R5: input below the window flags but keeps the result
        step(32'h3F800000, 1'b1, 1'b1);
        step(32'h30000000, 1'b0, 1'b1);
        step(32'h3F800000, 1'b0, 1'b1);
        flush();
        chk(x_lo && r_out === 32'h40000000, "R5 low flag with valid sum", r_out, 32'h40000000);

        // R4: infinity raises the high flag for the rest of the set
        step(32'h3F800000, 1'b1, 1'b1);
        step(32'h7F800000, 1'b0, 1'b1);
        step(32'h3F800000, 1'b0, 1'b1);
        flush();
        chk(32'(x_hi) === 32'd1, "R4 high flag sticky", 32'(x_hi), 32'd1);
        step(32'h3F800000, 1'b1, 1'b1);
        flush();
        chk(32'(x_hi) === 32'd0, "R4 cleared by start", 32'(x_hi), 32'd0);

        // R6: accumulator overflow and its clearing
        step(32'h47800000, 1'b1, 1'b1);
        for (int i = 0; i < 39; i++) step(32'h47800000, 1'b0, 1'b1);
        flush();
        chk(32'(acc_ovf) === 32'd1, "R6 overflow raised", 32'(acc_ovf), 32'd1);
        step(32'h3F800000, 1'b1, 1'b1);
        flush();
        chk(32'(acc_ovf) === 32'd0 && r_out === 32'h3F800000, "R6 cleared by start", r_out, 32'h3F800000);

        // R9: disabled cycles ignore data and start
        step(32'h40400000, 1'b1, 1'b1);
        flush();
        for (int i = 0; i < 5; i++) step(32'h7F800000, 1'b1, 1'b0);
        chk(r_out === 32'h40400000 && !x_hi, "R9 frozen while disabled", r_out, 32'h40400000);
        step(32'h3F800000, 1'b0, 1'b1);
        flush();
        chk(r_out === 32'h40800000, "R9 resumes without loss", r_out, 32'h40800000);

        // random sets of random length, with random idle cycles
        for (int s = 0; s < 250; s++) begin
            int len = $urandom_range(1, 12);
            for (int i = 0; i < len; i++) begin
                while ($urandom_range(0, 9) == 0) step(rnd_x(), $urandom_range(0, 1) == 1, 1'b0);
                step(rnd_x(), i == 0, 1'b1);
            end
        end
        flush();

        // R10: reset mid-operation clears everything
        step(32'h40400000, 1'b1, 1'b1);
        flush();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(r_out === 32'h0 && !x_hi && !x_lo && !acc_ovf, "R10 reset clears", r_out, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule